// File: doc/BRIEF.md
# Byte-Written Latched DAC Code Register

This block holds the 12-bit level code for an auxiliary digital-to-analog converter. Software reaches it over an 8-bit register bus, so a full code takes two writes: one to the low byte and one to the high byte. With a single register, the converter would briefly show a mix of old and new bytes between those two writes. Here the writes land in a staging register, and the active code only moves when a separate latch strobe arrives. The latch copies all twelve staged bits in one clock edge.

Bits 11:0 of the 16-bit register carry the code and bits 15:12 are unused. One LSB is about 0.61 mV, so full scale (4095) maps to 2.5 V at the analog side, which is outside this block. Reset clears both the staged and the active code, so the level must be written again after every reset. A readback port returns the staged value as a 16-bit word with zeros above bit 11.

Top module: `aux_level_reg`

## Requirements
- R1: While reset is asserted, and after it is released, both `activeCode` and `rdData` are zero until a write or a latch changes them.
- R2: A write with `wrAddr` = 0 stores `wrData[7:0]` into staged bits 7:0. It is visible on `rdData[7:0]` after that clock edge. Staged bits 11:8 are left as they were.
- R3: A write with `wrAddr` = 1 stores only `wrData[3:0]` into staged bits 11:8. `wrData[7:4]` is discarded, and staged bits 7:0 are left as they were.
- R4: A byte write never changes `activeCode`.
- R5: When `latchCmd` is high at a clock edge, `activeCode` takes all 12 staged bits at that edge.
- R6: While `latchCmd` is low, `activeCode` holds its value.
- R7: If a write and a latch fall on the same edge, `activeCode` takes the staged value from before that write, and the staged register takes the write.
- R8: `rdData` is the staged code zero-extended to 16 bits, so `rdData[15:12]` is always zero.
- R9: When `wrEn` is low, `wrAddr` and `wrData` have no effect on the staged code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write enable |
| wrAddr | input | 1 | Byte select: 0 = bits 7:0, 1 = bits 11:8 |
| wrData | input | 8 | Byte to write |
| latchCmd | input | 1 | Copy the staged code to the active code |
| activeCode | output | 12 | Code presented to the converter |
| rdData | output | 16 | Staged code, zero-extended |

## Verification
Every result in this block is due exactly one rising edge after its stimulus. A write shows on `rdData` after the edge that samples it, and a latch shows on `activeCode` after the edge that samples it. No result has any further pipeline delay. The bench drives inputs on the falling edge and waits for one rising edge. It updates its reference model at that rising edge, then compares both outputs at the next falling edge, so each sample sits half a period away from the edge that caused it. Because the model updates the active code from the staged value held before the write, the same-edge write-and-latch case is checked at this same one-edge offset.

// File: rtl/aux_level_pkg.sv
package aux_level_pkg;
  // Code and bus geometry; every derived width follows from these.
  parameter int unsigned CODE_W = 12;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned WORD_W = 16;

  localparam int unsigned NUM_LANES = (CODE_W + BYTE_W - 1) / BYTE_W;
  localparam int unsigned ADDR_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int unsigned PAD_W     = WORD_W - CODE_W;

  // Strobes passed from the control decoder to the datapath.
  typedef struct packed {
    logic [NUM_LANES-1:0] laneWe;
    logic                 latch;
  } auxStrobe_t;

  // Width of the given byte lane (the top lane may be partial).
  function automatic int unsigned laneWidth(input int unsigned lane);
    int unsigned rest;
    rest = CODE_W - lane * BYTE_W;
    return (rest < BYTE_W) ? rest : BYTE_W;
  endfunction
endpackage

// File: rtl/aux_level_ctrl.sv
module aux_level_ctrl
  import aux_level_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              latchCmd,
  output auxStrobe_t        strobe
);
  logic [NUM_LANES-1:0] laneHit;

  // One-hot lane decode; an address with no lane selects nothing.
  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_decode
    assign laneHit[gi] = (wrAddr == ADDR_W'(gi));
  end

  always_comb begin
    strobe        = '0;
    strobe.laneWe = wrEn ? laneHit : '0;
    strobe.latch  = latchCmd;
  end
endmodule

// File: rtl/aux_level_dp.sv
module aux_level_dp
  import aux_level_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  auxStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CODE_W-1:0] activeCode,
  output logic [WORD_W-1:0] rdData
);
  logic [CODE_W-1:0] stagedCode;

  // One staging register per byte lane; the top lane keeps only its valid bits.
  for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
    localparam int unsigned LO = gl * BYTE_W;
    localparam int unsigned LW = laneWidth(gl);
    logic [LW-1:0] laneQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 laneQ <= '0;
      else if (strobe.laneWe[gl]) laneQ <= wrData[LW-1:0];
    end

    assign stagedCode[LO +: LW] = laneQ;
  end

  // Active copy samples the staged value held before this edge's write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             activeCode <= '0;
    else if (strobe.latch) activeCode <= stagedCode;
  end

  assign rdData = {{PAD_W{1'b0}}, stagedCode};
endmodule

// File: rtl/aux_level_reg.sv
module aux_level_reg
  import aux_level_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [7:0]  wrData,
  input  logic        latchCmd,
  output logic [11:0] activeCode,
  output logic [15:0] rdData
);
  auxStrobe_t strobe;

  aux_level_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .latchCmd (latchCmd),
    .strobe   (strobe)
  );

  aux_level_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .activeCode (activeCode),
    .rdData     (rdData)
  );
endmodule

// File: rtl/aux_level_reg_chk.sv
module aux_level_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        wrAddr,
  input logic [7:0]  wrData,
  input logic        latchCmd,
  input logic [11:0] activeCode,
  input logic [15:0] rdData
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (activeCode == '0 && rdData == '0));

  p_low_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr) |=> (rdData[7:0] == $past(wrData) && $stable(rdData[11:8])));

  p_high_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> (rdData[11:8] == $past(wrData[3:0]) && $stable(rdData[7:0])));

  p_latch_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    latchCmd |=> (activeCode == $past(rdData[11:0])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !latchCmd |=> $stable(activeCode));

  p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:12] == 4'h0);

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));
endmodule

bind aux_level_reg aux_level_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .latchCmd(latchCmd), .activeCode(activeCode), .rdData(rdData)
);

// File: tb/aux_level_reg_tb.sv
module aux_level_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [7:0]  wrData = '0;
  logic        latchCmd = 1'b0;
  logic [11:0] activeCode;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [11:0] expStaged = '0;
  logic [11:0] expActive = '0;

  always #2.5 clk = ~clk;

  aux_level_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .latchCmd(latchCmd), .activeCode(activeCode), .rdData(rdData)
  );

  function automatic logic [11:0] nextStaged(input logic [11:0] cur, input logic we,
                                             input logic addr, input logic [7:0] d);
    if (!we)  return cur;
    if (addr) return {d[3:0], cur[7:0]};
    return {cur[11:8], d};
  endfunction

  task automatic check(input string tag);
    nChecks++;
    if (rdData !== {4'h0, expStaged}) begin
      nFails++;
      $display("FAIL %s rdData actual=%h expected=%h", tag, rdData, {4'h0, expStaged});
    end
    nChecks++;
    if (activeCode !== expActive) begin
      nFails++;
      $display("FAIL %s activeCode actual=%h expected=%h", tag, activeCode, expActive);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, check at next falling edge.
  task automatic step(input logic we, input logic addr, input logic [7:0] d,
                      input logic lat, input string tag);
    wrEn = we; wrAddr = addr; wrData = d; latchCmd = lat;
    @(posedge clk);
    if (lat) expActive = expStaged;
    expStaged = nextStaged(expStaged, we, addr, d);
    @(negedge clk);
    check(tag);
    wrEn = 1'b0; latchCmd = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    step(1'b1, 1'b0, 8'hA5, 1'b0, "R2");
    step(1'b1, 1'b1, 8'hF7, 1'b0, "R3");   // upper nibble dropped, active unchanged (R4, R8)
    step(1'b0, 1'b0, 8'h00, 1'b0, "R6");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R5");   // expect 0x7A5 active
    step(1'b0, 1'b1, 8'h3C, 1'b0, "R9");
    step(1'b0, 1'b0, 8'h11, 1'b0, "R9");
    step(1'b1, 1'b0, 8'hFF, 1'b0, "R4");
    step(1'b1, 1'b1, 8'hFF, 1'b0, "R4");   // staged 0xFFF, active 0x7A5
    step(1'b1, 1'b0, 8'h00, 1'b1, "R7");   // active 0xFFF, staged 0xF00
    step(1'b0, 1'b0, 8'h00, 1'b1, "R5");   // active 0xF00
    step(1'b1, 1'b1, 8'hA0, 1'b1, "R7");   // active 0xF00, staged 0x000
    step(1'b0, 1'b0, 8'h00, 1'b1, "R5");

    for (int i = 0; i < 400; i++) begin
      logic we, addr, lat;
      logic [7:0] d;
      we   = ($urandom() % 3) != 0;
      addr = 1'($urandom());
      lat  = ($urandom() % 4) == 0;
      d    = 8'($urandom());
      step(we, addr, d, lat, lat ? "R5" : (we ? (addr ? "R3" : "R2") : "R9"));
    end

    step(1'b1, 1'b1, 8'h0B, 1'b1, "R8");
    rstN = 1'b0;
    expStaged = '0; expActive = '0;
    @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R6");

    summary();
    $finish;
  end
endmodule